// File: doc/BRIEF.md
# Shift-Add Multiply-Accumulate Unit

This sequential unit evaluates the expression 1 + x + y + z*t on unsigned operands. All four operands arrive one at a time on a shared narrow input bus. Each operand is accepted only in a cycle where its valid strobe is high. The order is fixed: the multiplier t first, then the multiplicand z, then y, and then x. Each value is widened with zero bits to the accumulator width before it is stored or added.

One adder serves every summing step. The accumulator is cleared when a run starts. It then takes y, and then takes x together with an adder carry-in of one, which supplies the constant term. After that, a shift-and-add loop folds in the product. In each iteration the multiplicand is added into the accumulator when the multiplier's lowest bit is set. In the same cycle the multiplier moves right by one bit and the multiplicand moves left by one bit. The loop ends as soon as the multiplier register holds zero, so a small t finishes in few cycles.

When the loop exits, a one-cycle done pulse is raised. The result output holds the final sum, taken modulo 2^ACC_W, until the next run is started.

Top module: `shmac_top`

## Requirements
- R1: After a synchronous reset, result is 0 and done is 0.
- R2: Operands are taken in the order t, z, y, x, one per cycle in which opnd_valid is high while the unit waits for that operand. A cycle with opnd_valid low leaves the sequence and the stored values unchanged, and each operand is zero-extended from IN_W to ACC_W bits.
- R3: The final result equals (1 + x + y + z*t) mod 2^ACC_W for any unsigned operand values.
- R4: The constant 1 enters only as the adder carry-in of the x step: with t, y and x all zero, the result is exactly 1.
- R5: In each loop iteration, the add uses the multiplicand value from before that iteration's shift. The multiplier shifts right and the multiplicand shifts left on the same edge, whether or not an add took place.
- R6: The loop ends when the multiplier register is zero. done is first high exactly L+1 cycles after the edge that accepts x, where L is the bit length of t (L = 0 for t = 0, which gives result 1 + x + y).
- R7: done is high for exactly one cycle per run.
- R8: result holds its value from done until the next accepted start. The cycle after start is accepted, result reads 0.
- R9: A start asserted while a run is in progress is ignored and has no effect on the result or on the done timing.
- R10: Sums beyond ACC_W bits wrap: the carry-out is dropped (t = z = y = x = 255 gives 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new run when idle |
| opnd_valid | input | 1 | Operand on opnd_bus is valid this cycle |
| opnd_bus | input | IN_W | Shared operand input |
| result | output | ACC_W | Accumulated result, registered |
| done | output | 1 | One-cycle pulse when the loop has ended |

## Verification
The hardest situation to reach from the ports is a start request that arrives in the middle of the multiply loop. The unit must ignore it, and the only evidence of that is a correct final value with unchanged done timing. The stimulus pulses start one cycle into the loop of a run whose multiplier is long. It then checks the cycle count and the sum against the expected values. A second awkward case is a stall between operand strobes while the bus carries garbage. The stimulus inserts idle cycles with a fixed junk pattern on the bus between every pair of operands.

// File: rtl/shmac_pkg.sv
package shmac_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_GET_T = 3'd1,
    ST_GET_Z = 3'd2,
    ST_SUM_Y = 3'd3,
    ST_SUM_X = 3'd4,
    ST_LOOP  = 3'd5,
    ST_FIN   = 3'd6
  } shmac_state_e;

  typedef struct packed {
    logic clr;
    logic ld_mplr;
    logic ld_mcnd;
    logic acc_en;
    logic acc_sel_mcnd;
    logic acc_cin;
    logic shift_en;
  } shmac_ctl_t;

endpackage

// File: rtl/shmac_ctrl.sv
module shmac_ctrl
  import shmac_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         opnd_valid,
  input  logic         mplr_lsb,
  input  logic         mplr_nz,
  output shmac_ctl_t   ctl,
  output shmac_state_e state,
  output logic         done
);

  shmac_state_e nxt;

  always_comb begin
    nxt = state;
    ctl = '0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          ctl.clr = 1'b1;
          nxt     = ST_GET_T;
        end
      end
      ST_GET_T: begin
        if (opnd_valid) begin
          ctl.ld_mplr = 1'b1;
          nxt         = ST_GET_Z;
        end
      end
      ST_GET_Z: begin
        if (opnd_valid) begin
          ctl.ld_mcnd = 1'b1;
          nxt         = ST_SUM_Y;
        end
      end
      ST_SUM_Y: begin
        if (opnd_valid) begin
          ctl.acc_en = 1'b1;
          nxt        = ST_SUM_X;
        end
      end
      ST_SUM_X: begin
        if (opnd_valid) begin
          ctl.acc_en  = 1'b1;
          ctl.acc_cin = 1'b1;
          nxt         = ST_LOOP;
        end
      end
      ST_LOOP: begin
        if (mplr_nz) begin
          ctl.shift_en     = 1'b1;
          ctl.acc_en       = mplr_lsb;
          ctl.acc_sel_mcnd = 1'b1;
        end else begin
          nxt = ST_FIN;
        end
      end
      ST_FIN:  nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= nxt;
      done  <= (state == ST_LOOP) && !mplr_nz;
    end
  end

  // R7: the done pulse never lasts two cycles
  assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R6: the loop never shifts once the multiplier is empty
  assert_no_shift_when_empty_R6: assert property (@(posedge clk) disable iff (rst)
    !mplr_nz |-> !ctl.shift_en);

endmodule

// File: rtl/shmac_mplr.sv
module shmac_mplr #(
  parameter int IN_W  = 8,
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             load,
  input  logic             shift,
  input  logic [IN_W-1:0]  din,
  output logic             lsb,
  output logic             nz
);

  localparam int PAD = ACC_W - IN_W;

  logic [ACC_W-1:0] mplr_q;

  always_ff @(posedge clk) begin
    if (rst || clr)  mplr_q <= '0;
    else if (load)   mplr_q <= {{PAD{1'b0}}, din};
    else if (shift)  mplr_q <= mplr_q >> 1;
  end

  assign lsb = mplr_q[0];
  assign nz  = |mplr_q;

  // R5: each iteration moves the multiplier right by one bit
  assert_mplr_shift_R5: assert property (@(posedge clk) disable iff (rst)
    (shift && !load && !clr) |=> (mplr_q == ($past(mplr_q) >> 1)));

  // R2: a loaded value never has bits above the input width
  assert_mplr_zext_R2: assert property (@(posedge clk) disable iff (rst)
    load |=> (mplr_q >> IN_W) == '0);

endmodule

// File: rtl/shmac_mcnd.sv
module shmac_mcnd #(
  parameter int IN_W  = 8,
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             load,
  input  logic             shift,
  input  logic [IN_W-1:0]  din,
  output logic [ACC_W-1:0] mcnd
);

  localparam int PAD = ACC_W - IN_W;

  always_ff @(posedge clk) begin
    if (rst || clr)  mcnd <= '0;
    else if (load)   mcnd <= {{PAD{1'b0}}, din};
    else if (shift)  mcnd <= mcnd << 1;
  end

  // R5: each iteration moves the multiplicand left by one bit
  assert_mcnd_shift_R5: assert property (@(posedge clk) disable iff (rst)
    (shift && !load && !clr) |=> (mcnd == ($past(mcnd) << 1)));

endmodule

// File: rtl/shmac_accum.sv
module shmac_accum #(
  parameter int IN_W  = 8,
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic             sel_mcnd,
  input  logic             cin,
  input  logic [IN_W-1:0]  din,
  input  logic [ACC_W-1:0] mcnd,
  output logic [ACC_W-1:0] acc
);

  localparam int PAD = ACC_W - IN_W;

  logic [ACC_W-1:0] addend;
  logic [ACC_W-1:0] sum;

  assign addend = sel_mcnd ? mcnd : {{PAD{1'b0}}, din};
  // carry-out dropped on purpose: result is modulo 2^ACC_W
  assign sum    = acc + addend + {{(ACC_W-1){1'b0}}, cin};

  always_ff @(posedge clk) begin
    if (rst || clr) acc <= '0;
    else if (en)    acc <= sum;
  end

  // R8: an accepted start leaves the accumulator at zero
  assert_clear_zero_R8: assert property (@(posedge clk) disable iff (rst)
    clr |=> acc == '0);

  // R2: without an enable the accumulator holds
  assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (rst)
    (!en && !clr) |=> $stable(acc));

endmodule

// File: rtl/shmac_top.sv
module shmac_top
  import shmac_pkg::*;
#(
  parameter int IN_W  = 8,
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             opnd_valid,
  input  logic [IN_W-1:0]  opnd_bus,
  output logic [ACC_W-1:0] result,
  output logic             done
);

  shmac_ctl_t       ctl;
  shmac_state_e     state;
  logic             mplr_lsb;
  logic             mplr_nz;
  logic [ACC_W-1:0] mcnd;

  shmac_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .opnd_valid (opnd_valid),
    .mplr_lsb   (mplr_lsb),
    .mplr_nz    (mplr_nz),
    .ctl        (ctl),
    .state      (state),
    .done       (done)
  );

  shmac_mplr #(.IN_W(IN_W), .ACC_W(ACC_W)) u_mplr (
    .clk   (clk),
    .rst   (rst),
    .clr   (ctl.clr),
    .load  (ctl.ld_mplr),
    .shift (ctl.shift_en),
    .din   (opnd_bus),
    .lsb   (mplr_lsb),
    .nz    (mplr_nz)
  );

  shmac_mcnd #(.IN_W(IN_W), .ACC_W(ACC_W)) u_mcnd (
    .clk   (clk),
    .rst   (rst),
    .clr   (ctl.clr),
    .load  (ctl.ld_mcnd),
    .shift (ctl.shift_en),
    .din   (opnd_bus),
    .mcnd  (mcnd)
  );

  shmac_accum #(.IN_W(IN_W), .ACC_W(ACC_W)) u_accum (
    .clk      (clk),
    .rst      (rst),
    .clr      (ctl.clr),
    .en       (ctl.acc_en),
    .sel_mcnd (ctl.acc_sel_mcnd),
    .cin      (ctl.acc_cin),
    .din      (opnd_bus),
    .mcnd     (mcnd),
    .acc      (result)
  );

  // R5: an add in the loop uses the multiplicand from before its shift
  assert_add_preshift_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOOP && mplr_nz && mplr_lsb) |=>
      result == $past(result) + $past(mcnd));

  // R8: while idle and not started, the result does not move
  assert_idle_stable_R8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !start) |=> $stable(result));

  // R9: start has no effect while a run is in progress
  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |-> !ctl.clr);

endmodule

// File: tb/test_shmac_top.sv
module test_shmac_top;

  localparam int IN_W  = 8;
  localparam int ACC_W = 16;
  localparam int NVEC  = 8;

  // {t, z, y, x, expected}
  localparam logic [IN_W*4+ACC_W-1:0] VEC [NVEC] = '{
    {8'd10,  8'd2,   8'd1,   8'd2,   16'd24},
    {8'd0,   8'd200, 8'd7,   8'd9,   16'd17},
    {8'd255, 8'd255, 8'd255, 8'd255, 16'd0},
    {8'd1,   8'd1,   8'd0,   8'd0,   16'd2},
    {8'd128, 8'd3,   8'd10,  8'd20,  16'd415},
    {8'd0,   8'd0,   8'd0,   8'd0,   16'd1},
    {8'd200, 8'd150, 8'd100, 8'd50,  16'd30151},
    {8'd171, 8'd205, 8'd33,  8'd66,  16'd35155}
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic             opnd_valid = 1'b0;
  logic [IN_W-1:0]  opnd_bus = '0;
  logic [ACC_W-1:0] result;
  logic             done;

  int checks   = 0;
  int failures = 0;

  always #4 clk = ~clk;

  shmac_top #(.IN_W(IN_W), .ACC_W(ACC_W)) i_shmac_top (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .opnd_valid (opnd_valid),
    .opnd_bus   (opnd_bus),
    .result     (result),
    .done       (done)
  );

  function automatic int bitlen(input logic [IN_W-1:0] v);
    int n = 0;
    for (int i = 0; i < IN_W; i++) if (v[i]) n = i + 1;
    return n;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put(input logic [IN_W-1:0] v, input int gap);
    for (int g = 0; g < gap; g++) begin
      opnd_valid = 1'b0;
      opnd_bus   = 8'hA5;
      @(negedge clk);
    end
    opnd_valid = 1'b1;
    opnd_bus   = v;
    @(negedge clk);
  endtask

  task automatic run_op(input logic [IN_W-1:0] t, input logic [IN_W-1:0] z,
                        input logic [IN_W-1:0] y, input logic [IN_W-1:0] x,
                        input int gap, input bit start_mid,
                        output logic [ACC_W-1:0] res, output int lat);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R8 start clears", result, 0);
    put(t, gap);
    put(z, gap);
    put(y, gap);
    put(x, gap);
    opnd_valid = 1'b0;
    opnd_bus   = 8'h5A;
    lat = 0;
    while (!done && lat < 64) begin
      start = (start_mid && lat == 1);
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    res = result;
  endtask

  initial begin
    logic [ACC_W-1:0] res;
    int lat;
    logic [ACC_W-1:0] held;

    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 result", result, 0);
    check("R1 done", done, 0);
    rst = 1'b0;
    @(negedge clk);

    // R3, R6, R10: table of vectors
    for (int i = 0; i < NVEC; i++) begin
      logic [IN_W-1:0]  vt, vz, vy, vx;
      logic [ACC_W-1:0] ve;
      {vt, vz, vy, vx, ve} = VEC[i];
      run_op(vt, vz, vy, vx, 0, 1'b0, res, lat);
      check("R3 R10 result", res, ve);
      check("R6 latency", lat, bitlen(vt) + 1);
      @(negedge clk);
      // R7: pulse ends after one cycle
      check("R7 done pulse", done, 0);
    end

    // R4: constant from carry-in only
    run_op(8'd0, 8'd77, 8'd0, 8'd0, 0, 1'b0, res, lat);
    check("R4 constant one", res, 1);
    check("R6 zero multiplier exit", lat, 1);
    @(negedge clk);

    // R2: stalls with junk on the bus between operands
    run_op(8'd13, 8'd11, 8'd4, 8'd5, 3, 1'b0, res, lat);
    check("R2 stalled operands", res, 16'd153);
    check("R2 latency after stall", lat, 5);

    // R8: result stable after done with no start
    held = res;
    repeat (6) @(negedge clk);
    check("R8 hold after done", result, held);

    // R9: start during the loop is ignored
    run_op(8'd255, 8'd2, 8'd3, 8'd4, 0, 1'b1, res, lat);
    check("R9 start ignored result", res, 16'd518);
    check("R9 start ignored latency", lat, 9);
    @(negedge clk);

    // R5: alternating multiplier bits exercise add and no-add iterations
    run_op(8'd170, 8'd129, 8'd0, 8'd0, 0, 1'b0, res, lat);
    check("R5 alternating bits", res, 16'd21931);

    // R1: reset mid-run returns outputs to zero
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    put(8'd9, 0);
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset mid-run result", result, 0);
    check("R1 reset mid-run done", done, 0);
    rst = 1'b0;
    @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule